// File: doc/BRIEF.md
# Scatter/Gather Descriptor Chain Controller

This block chains block transfers for a single DMA channel. Software writes the first descriptor straight into the channel registers: source address, destination address, next-descriptor pointer and control word. It also writes a configuration word, then pulses a go input. The controller sends a one-cycle start pulse to the data-moving engine and waits for that engine's done pulse.

When the done pulse arrives, the controller examines the next-descriptor pointer. If the pointer is zero, the channel stops. Otherwise the controller reads four consecutive words from memory over a request/acknowledge read port. Those words are the new source, destination, next pointer and control values, in that order. Only after the fourth word is accepted does it load all four registers together and start the next block.

A bus error on any descriptor read aborts the chain. The configuration word never changes during a chained load.

Top module: `sg_chain_ctrl`

## Requirements
- R1: After reset, chan_en, chain_err, xfer_start and rd_req are 0, and all five channel registers read 0.
- R2: While chan_en is 0, a cycle with sw_we high writes sw_wdata into the register chosen by sw_sel: 0 source, 1 destination, 2 next pointer, 3 control, 4 configuration. While chan_en is 1, such writes are ignored.
- R3: sw_go while idle raises chan_en and produces exactly one xfer_start cycle in the cycle after go, with the registers holding the software-written values.
- R4: When xfer_done arrives and the next pointer is 0, chan_en drops in the following cycle, and no read is requested.
- R5: When xfer_done arrives and the next pointer is non-zero, four reads are issued. Their addresses are the pointer with bits 1:0 forced to 0, then +4, +8 and +12. Each rd_req is held with a stable address until rd_ack or rd_err.
- R6: The four read words load, in order, the source, destination, next pointer and control registers.
- R7: No channel register changes until the fourth word is accepted. After it is accepted, all four update together, and xfer_start pulses once with the new values.
- R8: The configuration register changes only through a software write. Chained loads never touch it.
- R9: rd_err during a descriptor read clears chan_en, sets chain_err, leaves all registers unchanged and gives no xfer_start. The next sw_go clears chain_err.
- R10: xfer_done is ignored unless the controller is waiting for a block to finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 3 | Register select for software writes |
| sw_wdata | input | 32 | Software write data |
| sw_go | input | 1 | Start the channel with the current registers |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_done | input | 1 | Block-complete pulse from the transfer engine |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor read byte address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| rd_err | input | 1 | Read bus error |
| src_addr | output | 32 | Channel source address |
| dst_addr | output | 32 | Channel destination address |
| next_ptr | output | 32 | Channel next-descriptor pointer |
| ctrl_word | output | 32 | Channel control word |
| cfg_word | output | 32 | Channel configuration word |
| chan_en | output | 1 | Channel active |
| chain_err | output | 1 | Sticky descriptor read error flag |

## Verification
Some rules can be checked on every cycle, and the assertions cover those:
- the start pulse never lasts more than one cycle;
- a pending read keeps its word-aligned address until it is answered;
- an error response always ends the channel with the flag set;
- the configuration word moves only after a software write;
- the address registers change during an active chain only together with a start pulse.

Other behaviour needs the bench's scenarios. These include:
- which memory word lands in which register;
- the address sequence across several chained descriptors with varying acknowledge latency;
- masking of a misaligned pointer;
- a register file left untouched by a fetch aborted on its third word;
- writes and done pulses that are ignored at the wrong moment.

// File: rtl/sg_chain_pkg.sv
package sg_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_RUN   = 3'd2,
    ST_FETCH = 3'd3,
    ST_LOAD  = 3'd4
  } sg_state_t;

  // register select codes used by software writes
  localparam logic [2:0] SEL_SRC = 3'd0;
  localparam logic [2:0] SEL_DST = 3'd1;
  localparam logic [2:0] SEL_NXT = 3'd2;
  localparam logic [2:0] SEL_CTL = 3'd3;
  localparam logic [2:0] SEL_CFG = 3'd4;

endpackage

// File: rtl/sg_desc_buf.sv
module sg_desc_buf #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [IDX_W-1:0]        cap_idx,
  input  logic [DATA_W-1:0]       cap_data,
  output logic [WORDS*DATA_W-1:0] words
);

  // one holding register per descriptor word, each with its own enable
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DATA_W-1:0] hold_q;
    logic              hold_en;

    assign hold_en = cap_en && (cap_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
      end else if (hold_en) begin
        hold_q <= cap_data;
      end
    end

    assign words[g*DATA_W +: DATA_W] = hold_q;
  end

endmodule

// File: rtl/sg_chan_regs.sv
module sg_chan_regs #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_we,
  input  logic [2:0]              sw_sel,
  input  logic [DATA_W-1:0]       sw_wdata,
  input  logic                    sw_allow,
  input  logic                    load_en,
  input  logic [WORDS*DATA_W-1:0] load_words,
  output logic [WORDS*DATA_W-1:0] desc_regs,
  output logic [DATA_W-1:0]       cfg_reg
);

  import sg_chain_pkg::*;

  logic sw_ok;
  assign sw_ok = sw_we && sw_allow;

  // descriptor-backed registers: select code equals word position
  for (genvar g = 0; g < WORDS; g++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    logic              sw_hit;

    assign sw_hit = sw_ok && (sw_sel == 3'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (load_en) begin
        r_q <= load_words[g*DATA_W +: DATA_W];
      end else if (sw_hit) begin
        r_q <= sw_wdata;
      end
    end

    assign desc_regs[g*DATA_W +: DATA_W] = r_q;
  end

  // configuration: software only, never reloaded
  logic cfg_hit;
  assign cfg_hit = sw_ok && (sw_sel == SEL_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_reg <= '0;
    end else if (cfg_hit) begin
      cfg_reg <= sw_wdata;
    end
  end

endmodule

// File: rtl/sg_fetch_fsm.sv
module sg_fetch_fsm #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(WORDS),
  localparam int ALIGN = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_go,
  input  logic              xfer_done,
  input  logic [ADDR_W-1:0] next_ptr,
  input  logic              rd_ack,
  input  logic              rd_err,
  output logic              chan_en,
  output logic              xfer_start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              load_en,
  output logic              chain_err
);

  import sg_chain_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  sg_state_t        st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             err_q, err_n;
  logic             idx_en, err_en;

  always_comb begin
    st_n  = st_q;
    idx_n = idx_q;
    err_n = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (sw_go) begin
          st_n  = ST_START;
          err_n = 1'b0;
        end
      end
      ST_START: st_n = ST_RUN;
      ST_RUN: begin
        if (xfer_done) begin
          if (next_ptr == '0) begin
            st_n = ST_IDLE;
          end else begin
            st_n  = ST_FETCH;
            idx_n = '0;
          end
        end
      end
      ST_FETCH: begin
        if (rd_err) begin
          st_n  = ST_IDLE;
          err_n = 1'b1;
          idx_n = '0;
        end else if (rd_ack) begin
          if (idx_q == LAST_IDX) begin
            st_n = ST_LOAD;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      end
      ST_LOAD: st_n = ST_START;
      default: st_n = ST_IDLE;
    endcase
  end

  assign idx_en = (idx_n != idx_q);
  assign err_en = (err_n != err_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_n;
    end
  end

  logic [ADDR_W-1:0] base_addr;
  assign base_addr = {next_ptr[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};

  assign chan_en    = (st_q != ST_IDLE);
  assign xfer_start = (st_q == ST_START);
  assign rd_req     = (st_q == ST_FETCH);
  assign rd_addr    = base_addr + (ADDR_W'(idx_q) << ALIGN);
  assign cap_en     = rd_req && rd_ack && !rd_err;
  assign cap_idx    = idx_q;
  assign load_en    = (st_q == ST_LOAD);
  assign chain_err  = err_q;

endmodule

// File: rtl/sg_chain_ctrl.sv
module sg_chain_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [2:0]        sw_sel,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              sw_go,
  output logic              xfer_start,
  input  logic              xfer_done,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [ADDR_W-1:0] next_ptr,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [DATA_W-1:0] cfg_word,
  output logic              chan_en,
  output logic              chain_err
);

  localparam int IDX_W = $clog2(WORDS);

  logic                    cap_en;
  logic [IDX_W-1:0]        cap_idx;
  logic                    load_en;
  logic [WORDS*DATA_W-1:0] buf_words;
  logic [WORDS*DATA_W-1:0] desc_regs;

  sg_fetch_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_go      (sw_go),
    .xfer_done  (xfer_done),
    .next_ptr   (next_ptr),
    .rd_ack     (rd_ack),
    .rd_err     (rd_err),
    .chan_en    (chan_en),
    .xfer_start (xfer_start),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .cap_en     (cap_en),
    .cap_idx    (cap_idx),
    .load_en    (load_en),
    .chain_err  (chain_err)
  );

  sg_desc_buf #(.DATA_W(DATA_W), .WORDS(WORDS)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .cap_data (rd_data),
    .words    (buf_words)
  );

  sg_chan_regs #(.DATA_W(DATA_W), .WORDS(WORDS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_we      (sw_we),
    .sw_sel     (sw_sel),
    .sw_wdata   (sw_wdata),
    .sw_allow   (!chan_en),
    .load_en    (load_en),
    .load_words (buf_words),
    .desc_regs  (desc_regs),
    .cfg_reg    (cfg_word)
  );

  // word order: 0 source, 1 destination, 2 next pointer, 3 control
  assign src_addr  = ADDR_W'(desc_regs[0*DATA_W +: DATA_W]);
  assign dst_addr  = ADDR_W'(desc_regs[1*DATA_W +: DATA_W]);
  assign next_ptr  = ADDR_W'(desc_regs[2*DATA_W +: DATA_W]);
  assign ctrl_word = desc_regs[3*DATA_W +: DATA_W];

endmodule

// File: rtl/sg_chain_chk.sv
module sg_chain_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_we,
  input logic [2:0]        sw_sel,
  input logic              xfer_start,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ack,
  input logic              rd_err,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [DATA_W-1:0] cfg_word,
  input logic              chan_en,
  input logic              chain_err
);

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !rd_err) |=> (rd_req && $stable(rd_addr)));

  // R5
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == 2'b00));

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_err) |=> (!chan_en && chain_err && !xfer_start));

  // R8
  cfg_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> ($past(sw_we) && ($past(sw_sel) == 3'd4) && !$past(chan_en)));

  // R7
  load_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chan_en) && (!$stable(src_addr) || !$stable(dst_addr))) |-> xfer_start);

endmodule

bind sg_chain_ctrl sg_chain_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_we      (sw_we),
  .sw_sel     (sw_sel),
  .xfer_start (xfer_start),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_ack     (rd_ack),
  .rd_err     (rd_err),
  .src_addr   (src_addr),
  .dst_addr   (dst_addr),
  .cfg_word   (cfg_word),
  .chan_en    (chan_en),
  .chain_err  (chain_err)
);

// File: tb/sg_chain_ctrl_bench.sv
module sg_chain_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        sw_we;
  logic [2:0]  sw_sel;
  logic [31:0] sw_wdata;
  logic        sw_go;
  logic        xfer_start;
  logic        xfer_done;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic        rd_err;
  logic [31:0] src_addr, dst_addr, next_ptr, ctrl_word, cfg_word;
  logic        chan_en, chain_err;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  sg_chain_ctrl u_sg_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .sw_go(sw_go), .xfer_start(xfer_start), .xfer_done(xfer_done),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_err(rd_err), .src_addr(src_addr), .dst_addr(dst_addr), .next_ptr(next_ptr),
    .ctrl_word(ctrl_word), .cfg_word(cfg_word), .chan_en(chan_en), .chain_err(chain_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // chain table: {descriptor byte address, src, dst, next, ctrl}
  localparam int NDESC = 3;
  localparam logic [159:0] CHAIN [NDESC] = '{
    {32'h0000_0104, 32'h1000_0400, 32'h2000_0400, 32'h0000_0203, 32'h0000_0022},
    {32'h0000_0200, 32'h1000_0800, 32'h2000_0800, 32'h0000_0300, 32'h0000_0033},
    {32'h0000_0300, 32'h0000_000A, 32'h0000_000B, 32'h0000_0000, 32'h0000_0044}
  };

  localparam logic [31:0] CFG_VAL = 32'h0000_C0F1;

  function automatic logic [31:0] fld(int e, int w);
    // w: 0 addr, 1 src, 2 dst, 3 next, 4 ctrl
    return CHAIN[e][159 - 32*w -: 32];
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    for (int e = 0; e < NDESC; e++) begin
      logic [31:0] b;
      b = fld(e, 0);
      if (a >= b && a < b + 32'd16) return fld(e, 1 + int'((a - b) >> 2));
    end
    return 32'hDEAD_BEEF;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: variable latency, optional error on a chosen word
  logic [31:0] exp_base;
  int          rsp_idx  = 0;
  int          rsp_wait = 0;
  int          err_word = -1;

  initial begin
    rd_ack  = 1'b0;
    rd_err  = 1'b0;
    rd_data = '0;
    forever begin
      @(negedge clk);
      rd_ack = 1'b0;
      rd_err = 1'b0;
      if (rd_req && rst_n) begin
        if (rsp_wait < (rsp_idx % 3)) begin
          rsp_wait++;
        end else begin
          rsp_wait = 0;
          // R5 address sequence
          check(rd_addr == exp_base + 32'(rsp_idx * 4), "R5 rd_addr",
                rd_addr, exp_base + 32'(rsp_idx * 4));
          if (err_word == rsp_idx) begin
            rd_err   = 1'b1;
            err_word = -1;
            rsp_idx  = 0;
          end else begin
            rd_ack  = 1'b1;
            rd_data = mem_word(rd_addr);
            rsp_idx = (rsp_idx == 3) ? 0 : rsp_idx + 1;
          end
        end
      end
    end
  end

  task automatic sw_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk);
    sw_go = 1'b1;
    @(negedge clk);
    sw_go = 1'b0;
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  // wait for the next start pulse, checking registers stay put meanwhile (R7)
  task automatic wait_start(input logic [31:0] old_src, input logic [31:0] old_ctl);
    int n = 0;
    while (!xfer_start && n < 200) begin
      if (src_addr != old_src || ctrl_word != old_ctl) begin
        check(1'b0, "R7 regs moved before full fetch", src_addr, old_src);
      end
      @(negedge clk);
      n++;
    end
    check(xfer_start, "R7 start after load", 32'(xfer_start), 32'd1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] prev_src, prev_ctl, prev_next;
    sw_we = 0; sw_sel = 0; sw_wdata = 0; sw_go = 0; xfer_done = 0;
    exp_base = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!chan_en && !chain_err && !xfer_start && !rd_req, "R1 flags", 
          {28'd0, chan_en, chain_err, xfer_start, rd_req}, 32'd0);
    check(src_addr == 0 && dst_addr == 0 && next_ptr == 0 && ctrl_word == 0 && cfg_word == 0,
          "R1 regs", src_addr | dst_addr | next_ptr | ctrl_word | cfg_word, 32'd0);

    // R10 done while idle ignored
    pulse_done();
    check(!chan_en && !rd_req && !xfer_start, "R10 idle done ignored",
          {29'd0, chan_en, rd_req, xfer_start}, 32'd0);

    // R2 software load of first descriptor; misaligned pointer 0x106
    sw_write(3'd0, 32'h1000_0000);
    sw_write(3'd1, 32'h2000_0000);
    sw_write(3'd2, 32'h0000_0106);
    sw_write(3'd3, 32'h0000_0011);
    sw_write(3'd4, CFG_VAL);
    check(src_addr == 32'h1000_0000, "R2 src write", src_addr, 32'h1000_0000);
    check(next_ptr == 32'h0000_0106, "R2 next write", next_ptr, 32'h0000_0106);
    check(cfg_word == CFG_VAL, "R2 cfg write", cfg_word, CFG_VAL);

    // R3 go
    @(negedge clk);
    sw_go = 1'b1;
    @(negedge clk);
    sw_go = 1'b0;
    check(xfer_start && chan_en, "R3 start after go", {30'd0, xfer_start, chan_en}, 32'd3);
    check(ctrl_word == 32'h11, "R3 regs at start", ctrl_word, 32'h11);
    @(negedge clk);
    check(!xfer_start, "R3 single pulse", 32'(xfer_start), 32'd0);

    // R2 write while active ignored
    sw_write(3'd0, 32'hFFFF_FFFF);
    check(src_addr == 32'h1000_0000, "R2 write ignored while active", src_addr, 32'h1000_0000);

    prev_src  = src_addr;
    prev_ctl  = ctrl_word;
    prev_next = next_ptr;

    // table walk: each entry is one chained descriptor (R5 R6 R7 R8)
    for (int i = 0; i < NDESC; i++) begin
      exp_base = {prev_next[31:2], 2'b00};
      rsp_idx  = 0;
      pulse_done();
      wait_start(prev_src, prev_ctl);
      check(src_addr  == fld(i, 1), "R6 src",  src_addr,  fld(i, 1));
      check(dst_addr  == fld(i, 2), "R6 dst",  dst_addr,  fld(i, 2));
      check(next_ptr  == fld(i, 3), "R6 next", next_ptr,  fld(i, 3));
      check(ctrl_word == fld(i, 4), "R6 ctrl", ctrl_word, fld(i, 4));
      check(cfg_word  == CFG_VAL,   "R8 cfg kept", cfg_word, CFG_VAL);
      @(negedge clk);
      check(!xfer_start, "R10 one start per block", 32'(xfer_start), 32'd0);
      prev_src  = src_addr;
      prev_ctl  = ctrl_word;
      prev_next = next_ptr;
    end

    // R4 zero pointer stops channel
    pulse_done();
    check(!chan_en && !rd_req, "R4 stop on zero pointer", {30'd0, chan_en, rd_req}, 32'd0);
    repeat (3) @(negedge clk);
    check(!rd_req && !xfer_start, "R4 no fetch", {30'd0, rd_req, xfer_start}, 32'd0);

    // R9 error on third descriptor word
    sw_write(3'd0, 32'h0000_0055);
    sw_write(3'd1, 32'h0000_0066);
    sw_write(3'd2, 32'h0000_0500);
    pulse_go();
    check(xfer_start, "R3 second go", 32'(xfer_start), 32'd1);
    @(negedge clk);
    exp_base = 32'h0000_0500;
    rsp_idx  = 0;
    err_word = 2;
    pulse_done();
    begin
      int n = 0;
      int starts = 0;
      while (chan_en && n < 100) begin
        if (xfer_start) starts++;
        @(negedge clk);
        n++;
      end
      check(starts == 0, "R9 no start after error", 32'(starts), 32'd0);
    end
    check(!chan_en && chain_err, "R9 abort flags", {30'd0, chan_en, chain_err}, 32'd1);
    check(src_addr == 32'h55 && dst_addr == 32'h66, "R9 regs unchanged", src_addr, 32'h55);
    check(next_ptr == 32'h500, "R7 next unchanged after partial fetch", next_ptr, 32'h500);
    check(cfg_word == CFG_VAL, "R8 cfg after error", cfg_word, CFG_VAL);

    // R9 go clears the flag
    sw_write(3'd2, 32'h0);
    pulse_go();
    check(!chain_err && chan_en, "R9 flag cleared by go", {30'd0, chain_err, chan_en}, 32'd1);
    @(negedge clk);
    pulse_done();
    check(!chan_en, "R4 single block stop", 32'(chan_en), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule